// File: doc/BRIEF.md
# Paged Serial Configuration Bitstream Reader

This block is the read side of a bit-serial configuration store that feeds a programmable logic device running in master serial mode. The device being configured supplies the clock. It holds an active-low select and drives one combined pin: when that pin is low it clears the bit counters, and when it is high it enables the output. While the block is selected and enabled, every clock moves the read pointer on by one bit. The bit at the current pointer is presented on a serial data output, together with a qualifier that says when the data line is being driven.

The bit array can be read as a whole or as one of four equal pages chosen by a two-bit index. This lets a single store hold several bitstreams. When the last bit of the active range has been clocked out, the block releases the data line and pulls its cascade output low, so the next store in a chain can take over. A mode input selects read mode or programming mode; the programming protocol itself is not modelled. A ready flag stays low for a fixed number of cycles after the global reset is released. A synchronous write port fills the array.

Top module: `cfg_bitstream_reader`

## Requirements
- R1: After `rst_n` is released, `por_done` stays 0 for exactly `POR_CYCLES` rising clock edges and is 1 from then on. While it is 0, `dout_en` is 0 and `cascade_n` is 1.
- R2: While `oe_clr_n` is 0, `dout_en` is 0 and `cascade_n` is 1 whatever the level of `sel_n`. Each clock edge in that state reloads the read pointer with the start of the active range, so the first bit seen after `oe_clr_n` rises is the range's first bit.
- R3: While `read_mode`=1, `por_done`=1, `oe_clr_n`=1 and `sel_n`=0, `dout_en` is 1 until the range is exhausted. Each rising edge moves the pointer on by one bit. The current bit is valid before the first edge.
- R4: While `sel_n`=1 in read mode, the pointer is frozen, `dout_en` is 0 and `idle_stby` is 1. Reading resumes at the bit where it stopped.
- R5: With `paging_on`=1 and `page_idx`=p, the active range runs from bit p*DEPTH/4 to bit (p+1)*DEPTH/4-1.
- R6: With `paging_on`=0, `page_idx` is ignored and the active range is bits 0 to DEPTH-1.
- R7: The edge that clocks out the last bit of the range drives `cascade_n` to 0 and `dout_en` to 0. The pointer then holds and does not wrap; no further bit is driven until `oe_clr_n` goes low.
- R8: Once the range is exhausted and `oe_clr_n` is 1, `cascade_n` equals `sel_n`. When `oe_clr_n` goes low, `cascade_n` returns to 1 and stays there until the range has been read out again.
- R9: While `read_mode`=0, `dout_en`=0, `cascade_n`=1 and `idle_stby`=0 whatever `sel_n` and the paging inputs are. The pointer is reloaded, so reading restarts at the range start when read mode returns.
- R10: A clock edge with `wr_en`=1 stores `wr_data` at bit `wr_addr`, and a later read of that bit returns the stored value.
- R11: `dout` is 0 whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, supplied by the device being configured |
| rst_n | input | 1 | Global asynchronous reset, active low |
| sel_n | input | 1 | Select, active low; high means standby |
| oe_clr_n | input | 1 | Low clears the pointer; high enables the output |
| read_mode | input | 1 | 1 = read mode, 0 = programming mode |
| paging_on | input | 1 | 1 = the array is split into four pages |
| page_idx | input | 2 | Selected page when paging is on |
| wr_en | input | 1 | Write strobe for the preload port |
| wr_addr | input | AW | Bit index to write |
| wr_data | input | 1 | Bit value to write |
| dout | output | 1 | Serial configuration data |
| dout_en | output | 1 | High while `dout` is driven |
| cascade_n | output | 1 | Low when this store is exhausted; feeds the next store's select |
| por_done | output | 1 | Power-on interval complete |
| idle_stby | output | 1 | Standby indicator |

## Verification
The state that is hardest to reach is the end of a range. The pointer has to walk every bit of a page, or of the whole array, before `cascade_n` can fall. Once there, `sel_n` and `oe_clr_n` have to be moved in the right order to show that `cascade_n` follows the select, that the pointer does not wrap, and that clearing restarts the stream. The stimulus preloads a computed pattern through the write port and reads complete ranges: the whole array and two different pages. It then toggles the select and the clear at the exhausted end. A cycle model in the bench follows the same input sequence and is compared against the outputs on every clock.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  // First bit of the active range for a given paging setup.
  function automatic int unsigned range_lo(int unsigned depth, logic paged, logic [1:0] idx);
    int unsigned quarter;
    quarter = depth / 4;
    return paged ? int'(idx) * quarter : 0;
  endfunction

  // Last bit of the active range for a given paging setup.
  function automatic int unsigned range_hi(int unsigned depth, logic paged, logic [1:0] idx);
    int unsigned quarter;
    quarter = depth / 4;
    return paged ? (int'(idx) + 1) * quarter - 1 : depth - 1;
  endfunction

endpackage

// File: rtl/cfgr_por.sv
module cfgr_por #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt != CW'(CYCLES))
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == CW'(CYCLES));
endmodule

// File: rtl/cfgr_bit_array.sv
module cfgr_bit_array #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [DEPTH-1:0] store;

  always_ff @(posedge clk) begin
    if (wr_en)
      store[wr_addr] <= wr_data;
  end

  // Asynchronous read: the bit at the pointer is valid as soon as the pointer settles.
  assign rd_bit = store[rd_addr];
endmodule

// File: rtl/cfgr_addr_ctr.sv
module cfgr_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          step,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic [AW-1:0] ptr,
  output logic          spent
);
  logic at_last;
  assign at_last = (ptr == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      spent <= 1'b0;
    end else if (reload) begin
      ptr   <= first;
      spent <= 1'b0;
    end else if (step && !spent) begin
      if (at_last)
        spent <= 1'b1;
      else
        ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/cfgr_out_stage.sv
module cfgr_out_stage (
  input  logic read_mode,
  input  logic por_done,
  input  logic oe_clr_n,
  input  logic sel_n,
  input  logic spent,
  input  logic cur_bit,
  output logic dout,
  output logic dout_en,
  output logic cascade_n,
  output logic idle_stby
);
  logic live;
  assign live      = read_mode && por_done && oe_clr_n;
  assign dout_en   = live && !sel_n && !spent;
  assign dout      = dout_en && cur_bit;
  assign cascade_n = !(live && spent && !sel_n);
  assign idle_stby = read_mode && sel_n;
endmodule

// File: rtl/cfg_bitstream_reader.sv
module cfg_bitstream_reader #(
  parameter int DEPTH      = 256,
  parameter int POR_CYCLES = 16,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          oe_clr_n,
  input  logic          read_mode,
  input  logic          paging_on,
  input  logic [1:0]    page_idx,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  output logic          dout,
  output logic          dout_en,
  output logic          cascade_n,
  output logic          por_done,
  output logic          idle_stby
);
  // Named internal events, visible to the bound checker.
  logic [AW-1:0] rng_lo;
  logic [AW-1:0] rng_hi;
  logic [AW-1:0] cur_ptr;
  logic          range_spent;
  logic          ptr_reload;
  logic          cur_bit;

  assign rng_lo = AW'(cfgr_pkg::range_lo(DEPTH, paging_on, page_idx));
  assign rng_hi = AW'(cfgr_pkg::range_hi(DEPTH, paging_on, page_idx));

  assign ptr_reload = !read_mode || !por_done || !oe_clr_n;

  cfgr_por #(.CYCLES(POR_CYCLES)) u_por (
    .clk  (clk),
    .rst_n(rst_n),
    .done (por_done)
  );

  cfgr_addr_ctr #(.AW(AW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .reload(ptr_reload),
    .step  (!sel_n),
    .first (rng_lo),
    .last  (rng_hi),
    .ptr   (cur_ptr),
    .spent (range_spent)
  );

  cfgr_bit_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(cur_ptr),
    .rd_bit (cur_bit)
  );

  cfgr_out_stage u_out (
    .read_mode(read_mode),
    .por_done (por_done),
    .oe_clr_n (oe_clr_n),
    .sel_n    (sel_n),
    .spent    (range_spent),
    .cur_bit  (cur_bit),
    .dout     (dout),
    .dout_en  (dout_en),
    .cascade_n(cascade_n),
    .idle_stby(idle_stby)
  );
endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_n,
  input logic          oe_clr_n,
  input logic          read_mode,
  input logic          paging_on,
  input logic [1:0]    page_idx,
  input logic          dout,
  input logic          dout_en,
  input logic          cascade_n,
  input logic          por_done,
  input logic          idle_stby,
  input logic [AW-1:0] ptr,
  input logic          spent,
  input logic [AW-1:0] lo,
  input logic [AW-1:0] hi
);
  p_por_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |-> !dout_en && cascade_n);

  p_clear_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_clr_n |-> !dout_en && cascade_n);

  p_reload_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_clr_n) && $stable(paging_on) && $stable(page_idx) |-> ptr == lo);

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode && por_done && oe_clr_n && !sel_n && !spent && ptr != hi
    |=> ptr == $past(ptr) + 1'b1);

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode && por_done && oe_clr_n && sel_n |=> $stable(ptr) && $stable(spent));

  p_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode && sel_n |-> idle_stby && !dout_en);

  p_hold_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spent && read_mode && por_done && oe_clr_n |=> $stable(ptr) && spent);

  p_cascade_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cascade_n |-> !dout_en && spent);

  p_follow_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spent && read_mode && por_done && oe_clr_n |-> cascade_n == sel_n);

  p_prog_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !read_mode |-> !dout_en && cascade_n && !idle_stby);

  p_zero_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> !dout);
endmodule

bind cfg_bitstream_reader cfgr_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_n    (sel_n),
  .oe_clr_n (oe_clr_n),
  .read_mode(read_mode),
  .paging_on(paging_on),
  .page_idx (page_idx),
  .dout     (dout),
  .dout_en  (dout_en),
  .cascade_n(cascade_n),
  .por_done (por_done),
  .idle_stby(idle_stby),
  .ptr      (cur_ptr),
  .spent    (range_spent),
  .lo       (rng_lo),
  .hi       (rng_hi)
);

// File: tb/cfg_bitstream_reader_tb.sv
module cfg_bitstream_reader_tb;
  localparam int N   = 256;
  localparam int Q   = N / 4;
  localparam int POR = 16;
  localparam int AW  = $clog2(N);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, sel_n = 1'b1, oe_clr_n = 1'b0, read_mode = 1'b1;
  logic paging_on = 1'b0, wr_en = 1'b0, wr_data = 1'b0;
  logic [1:0] page_idx = 2'b00;
  logic [AW-1:0] wr_addr = '0;
  logic dout, dout_en, cascade_n, por_done, idle_stby;

  cfg_bitstream_reader #(.DEPTH(N), .POR_CYCLES(POR)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .oe_clr_n(oe_clr_n),
    .read_mode(read_mode), .paging_on(paging_on), .page_idx(page_idx),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout), .dout_en(dout_en), .cascade_n(cascade_n),
    .por_done(por_done), .idle_stby(idle_stby));

  // Reference model state
  bit    m_mem [N];
  int    m_ptr = 0, m_por = 0;
  bit    m_spent = 0, m_rdy = 0;
  int    errors = 0, checks = 0, cyc = 0;
  string phase = "R1";

  function automatic int lo_of(bit pe, int ps); return pe ? ps * Q : 0; endfunction
  function automatic int hi_of(bit pe, int ps); return pe ? (ps + 1) * Q - 1 : N - 1; endfunction
  function automatic bit pat(int i); return bit'(((i * 5 + (i >> 3)) >> 1) & 1) ^ (i % 3 == 0); endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ptr = 0; m_spent = 0; m_por = 0;
    end else begin
      m_rdy = (m_por >= POR);
      if (wr_en) m_mem[wr_addr] = wr_data;
      if (!read_mode || !m_rdy || !oe_clr_n) begin
        m_ptr = lo_of(paging_on, page_idx); m_spent = 0;
      end else if (!sel_n && !m_spent) begin
        if (m_ptr == hi_of(paging_on, page_idx)) m_spent = 1;
        else m_ptr++;
      end
      if (m_por < POR) m_por++;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    bit rdy, en, ceo, stb, d;
    rdy = rst_n && (m_por >= POR);
    en  = read_mode && rdy && oe_clr_n && !sel_n && !m_spent;
    d   = en && m_mem[m_ptr];
    ceo = !(read_mode && rdy && oe_clr_n && m_spent && !sel_n);
    stb = read_mode && sel_n;
    check(por_done == rdy, phase, por_done, rdy, "por_done vs model");
    check(dout_en == en, phase, dout_en, en, "dout_en vs model");
    check(dout == d, phase, dout, d, "dout vs model (R11 when idle)");
    check(cascade_n == ceo, phase, cascade_n, ceo, "cascade_n vs model");
    check(idle_stby == stb, phase, idle_stby, stb, "idle_stby vs model");
  end

  task automatic tick(); @(posedge clk); #5; endtask

  task automatic arm(bit pe, int ps);
    sel_n = 1'b1; oe_clr_n = 1'b0; paging_on = pe; page_idx = 2'(ps);
    tick(); tick();
    oe_clr_n = 1'b1; sel_n = 1'b0;
  endtask

  task automatic stream(int first, int count, string req);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      check(dout_en && dout == m_mem[first + i], req, dout, m_mem[first + i], "stream bit");
      tick();
    end
  endtask

  initial begin
    int k;
    #5;
    repeat (3) tick();
    @(negedge clk);
    check(!por_done && !dout_en && cascade_n, "R1", por_done, 0, "reset state");
    rst_n = 1'b1;
    k = 0;
    while (!por_done) begin tick(); k++; end
    check(k == POR, "R1", k, POR, "power-on interval length");

    phase = "R10";
    for (int i = 0; i < N; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(i); tick();
    end
    wr_en = 1'b0;

    phase = "R6";
    arm(1'b0, 3);
    stream(0, N, "R6");
    @(negedge clk);
    check(!cascade_n && !dout_en, "R7", cascade_n, 0, "cascade after full range");

    phase = "R8";
    tick(); sel_n = 1'b1; @(negedge clk);
    check(cascade_n == 1'b1, "R8", cascade_n, 1, "cascade follows sel high");
    tick(); sel_n = 1'b0; repeat (3) tick(); @(negedge clk);
    check(!cascade_n && !dout_en, "R7", dout_en, 0, "no wrap after end");
    tick(); oe_clr_n = 1'b0; @(negedge clk);
    check(cascade_n && !dout_en, "R2", cascade_n, 1, "clear releases cascade with sel low");
    tick(); oe_clr_n = 1'b1; @(negedge clk);
    check(dout_en && dout == pat(0), "R2", dout, pat(0), "restart at range start");
    tick();

    phase = "R5";
    arm(1'b1, 1);
    stream(Q, Q, "R5");
    @(negedge clk);
    check(!cascade_n, "R5", cascade_n, 0, "page 1 end");
    arm(1'b1, 3);
    stream(3 * Q, Q, "R5");
    @(negedge clk);
    check(!cascade_n, "R5", cascade_n, 0, "page 3 end");

    phase = "R4";
    arm(1'b1, 0);
    stream(0, 10, "R3");
    sel_n = 1'b1; repeat (4) tick(); @(negedge clk);
    check(idle_stby && !dout_en, "R4", idle_stby, 1, "standby while deselected");
    tick(); sel_n = 1'b0; @(negedge clk);
    check(dout_en && dout == m_mem[10], "R4", dout, m_mem[10], "resume at frozen bit");
    tick();
    oe_clr_n = 1'b0; sel_n = 1'b1; @(negedge clk);
    check(!dout_en && cascade_n, "R2", dout_en, 0, "clear with sel high");

    phase = "R9";
    arm(1'b1, 2);
    stream(2 * Q, 5, "R9");
    read_mode = 1'b0; page_idx = 2'd0; sel_n = 1'b1; tick(); @(negedge clk);
    check(!dout_en && cascade_n && !idle_stby, "R9", idle_stby, 0, "programming mode quiet");
    page_idx = 2'd2; sel_n = 1'b0; tick(); @(negedge clk);
    check(!dout_en && cascade_n, "R9", dout_en, 0, "programming mode sel low");
    tick(); read_mode = 1'b1; @(negedge clk);
    check(dout_en && dout == m_mem[2 * Q], "R9", dout, m_mem[2 * Q], "restart after mode return");
    tick();

    phase = "R10";
    oe_clr_n = 1'b0; wr_en = 1'b1; wr_addr = AW'(5); wr_data = !pat(5); tick();
    wr_en = 1'b0;
    arm(1'b0, 0);
    stream(0, 5, "R10");
    @(negedge clk);
    check(dout_en && dout == !pat(5), "R10", dout, !pat(5), "rewritten bit read back");
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule